// File: doc/BRIEF.md
# RISC Instruction Format Decoder

This block decodes a 32-bit instruction word from a RISC set that has three encoding formats. The formats are immediate, register and long-jump. Its outputs are the format, the three register indices, the three immediate fields, a one-hot operation class and, for memory operations, the access width and sign-extension flag. It also raises one of two exception flags. One flags an encoding that is not defined. The other flags an encoding that is defined but not supported.

The low six bits are the main opcode. One value of the main opcode acts as an escape. For that value, the operation comes from a second six-bit opcode in the middle of the word. The block does no execution, no register access and no exception entry. A following stage reads the outputs and acts on them.

A parameter selects whether the outputs are registered. When registered, they appear one clock after the input word and are cleared by a synchronous active-high reset.

Top module: `insn_fmt_decoder`

## Requirements
- R1: The field outputs come from fixed bit positions for every opcode: reg A = word[31:27], reg B = word[26:22], reg C = word[21:17], 5-bit immediate = word[10:6], 16-bit immediate = word[21:6], 26-bit immediate = word[31:6].
- R2: The format code is 2 (jump) for main opcodes 0x00 and 0x01, 1 (register) for main opcode 0x3A, and 0 (immediate) for every other main opcode.
- R3: The class output is one-hot. The bit positions are: 0 load, 1 store, 2 ALU-immediate, 3 ALU-register, 4 compare, 5 branch, 6 jump, 7 control-register access, 8 trap/break, 9 no-op. Main opcodes 0x03/0x23, 0x07/0x27, 0x0B/0x2B, 0x0F/0x2F and 0x17/0x37 are loads. Their size and sign are: unsigned byte, signed byte, unsigned half, signed half, word. Size codes are 0 byte, 1 half, 2 word. The sign flag is 1 only for signed byte and signed half.
- R4: Main opcodes 0x05/0x25, 0x0D/0x2D and 0x15/0x35 are stores of byte, half and word. The sign flag is 0 for all of them.
- R5: Main opcodes 0x06, 0x0E, 0x16, 0x1E, 0x26, 0x2E and 0x36 are branches. Main opcodes 0x00 and 0x01 are jumps.
- R6: Main opcodes 0x04, 0x0C, 0x14, 0x1C, 0x24, 0x2C, 0x34 and 0x3C are ALU-immediate. Main opcodes 0x08, 0x10, 0x18, 0x20, 0x28 and 0x30 are compares.
- R7: Main opcodes 0x02, 0x09, 0x0A, 0x11, 0x12, 0x19, 0x1A, 0x1D, 0x1F, 0x21, 0x22, 0x29, 0x2A, 0x31, 0x39, 0x3D, 0x3E and 0x3F raise the illegal flag. Main opcodes 0x32 and 0x38 raise the unimplemented flag.
- R8: These encodings are no-ops: main opcodes 0x13, 0x1B, 0x33 and 0x3B, and secondary opcodes 0x04, 0x0C, 0x29 and 0x36.
- R9: Under the escape, these secondary opcodes are jumps: 0x01, 0x05, 0x09, 0x0D and 0x1D. Opcodes 0x26 and 0x2E are control-register access. Opcodes 0x2D and 0x34 are trap/break. Opcodes 0x08, 0x10, 0x18, 0x20, 0x28 and 0x30 are compares.
- R10: Under the escape, these secondary opcodes are ALU-register: 0x02, 0x03, 0x06, 0x07, 0x0B, 0x0E, 0x12, 0x13, 0x16, 0x17, 0x1A, 0x1B, 0x1C, 0x1E, 0x1F, 0x24, 0x25, 0x27, 0x31, 0x39, 0x3A and 0x3B.
- R11: Under the escape, secondary opcode 0x14 raises the unimplemented flag. Every secondary opcode not listed in R8 to R10 raises the illegal flag, including 0x00.
- R12: When neither the load bit nor the store bit is set, the size and sign outputs are 0.
- R13: The illegal and unimplemented flags are never both set. Exactly one class bit is set when neither flag is set. No class bit is set when either flag is set.
- R14: With the output stage enabled (the default), outputs follow the input word one clock later. Reset drives all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 32 | Instruction word to decode |
| fmt_o | output | 2 | Format code: 0 immediate, 1 register, 2 jump |
| reg_a_o | output | 5 | Register index A |
| reg_b_o | output | 5 | Register index B |
| reg_c_o | output | 5 | Register index C |
| imm5_o | output | 5 | 5-bit immediate field |
| imm16_o | output | 16 | 16-bit immediate field |
| imm26_o | output | 26 | 26-bit immediate field |
| op_class_o | output | 10 | One-hot operation class |
| mem_size_o | output | 2 | Access size for loads and stores |
| mem_signed_o | output | 1 | Sign-extend flag for loads |
| illegal_o | output | 1 | Undefined encoding |
| unimpl_o | output | 1 | Defined but unsupported encoding |

## Verification
All 64 main opcodes are applied under four different background bit patterns. This shows that the class depends only on the opcode bits and not on field contents that happen to match another encoding. All 64 secondary opcodes are applied under three backgrounds. This separates the escape path from the main path and checks every hole in the secondary space. A walking-one sweep over bits 6 to 31 shows that each field bit lands in the right output and nowhere else. A final pair of words one cycle apart shows that the output holds the old decode until the next clock edge.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

    localparam int INSN_W  = 32;
    localparam int OPC_W   = 6;
    localparam int REG_W   = 5;
    localparam int IMM5_W  = 5;
    localparam int IMM16_W = 16;
    localparam int IMM26_W = 26;

    // Field positions; the decode and the register-file neighbour rely on them
    localparam int OPC_LSB = 0;
    localparam int IMM_LSB = OPC_LSB + OPC_W;
    localparam int XOP_LSB = IMM_LSB + IMM5_W;
    localparam int RC_LSB  = XOP_LSB + OPC_W;
    localparam int RB_LSB  = RC_LSB + REG_W;
    localparam int RA_LSB  = RB_LSB + REG_W;

    localparam logic [OPC_W-1:0] ESC_OPC = 6'h3A;

    typedef enum logic [1:0] {
        FMT_I = 2'd0,
        FMT_R = 2'd1,
        FMT_J = 2'd2
    } fmt_e;

    typedef enum logic [3:0] {
        OC_LOAD   = 4'd0,
        OC_STORE  = 4'd1,
        OC_ALUI   = 4'd2,
        OC_ALUR   = 4'd3,
        OC_CMP    = 4'd4,
        OC_BRANCH = 4'd5,
        OC_JUMP   = 4'd6,
        OC_CTRL   = 4'd7,
        OC_TRAP   = 4'd8,
        OC_NOP    = 4'd9
    } op_cls_e;

    localparam int NUM_CLS = 10;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } msize_e;

    typedef struct packed {
        logic [REG_W-1:0]   ra;
        logic [REG_W-1:0]   rb;
        logic [REG_W-1:0]   rc;
        logic [IMM5_W-1:0]  imm5;
        logic [IMM16_W-1:0] imm16;
        logic [IMM26_W-1:0] imm26;
        logic [OPC_W-1:0]   opc;
        logic [OPC_W-1:0]   xop;
    } fields_t;

    typedef struct packed {
        op_cls_e cls;
        logic    cls_vld;
        logic    illegal;
        logic    unimpl;
        msize_e  msize;
        logic    msigned;
    } dec_t;

    typedef struct packed {
        logic [REG_W-1:0]   ra;
        logic [REG_W-1:0]   rb;
        logic [REG_W-1:0]   rc;
        logic [IMM5_W-1:0]  imm5;
        logic [IMM16_W-1:0] imm16;
        logic [IMM26_W-1:0] imm26;
        fmt_e               fmt;
        logic [NUM_CLS-1:0] cls_oh;
        logic               illegal;
        logic               unimpl;
        msize_e             msize;
        logic               msigned;
    } dout_t;

    function automatic dec_t mk_cls(op_cls_e c);
        dec_t d;
        d         = '0;
        d.cls     = c;
        d.cls_vld = 1'b1;
        return d;
    endfunction

    function automatic dec_t mk_mem(op_cls_e c, msize_e s, logic sg);
        dec_t d;
        d         = mk_cls(c);
        d.msize   = s;
        d.msigned = sg;
        return d;
    endfunction

    function automatic dec_t mk_bad(logic is_unimpl);
        dec_t d;
        d         = '0;
        d.illegal = ~is_unimpl;
        d.unimpl  = is_unimpl;
        return d;
    endfunction

endpackage

// File: rtl/ifd_field_split.sv
module ifd_field_split
    import ifd_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output fields_t           flds
);
    always_comb begin
        flds.opc   = insn[OPC_LSB +: OPC_W];
        flds.imm5  = insn[IMM_LSB +: IMM5_W];
        flds.imm16 = insn[IMM_LSB +: IMM16_W];
        flds.imm26 = insn[IMM_LSB +: IMM26_W];
        flds.xop   = insn[XOP_LSB +: OPC_W];
        flds.rc    = insn[RC_LSB +: REG_W];
        flds.rb    = insn[RB_LSB +: REG_W];
        flds.ra    = insn[RA_LSB +: REG_W];
    end
endmodule

// File: rtl/ifd_primary_dec.sv
module ifd_primary_dec
    import ifd_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output dec_t             dec
);
    always_comb begin
        case (opc)
            6'h00, 6'h01:                      dec = mk_cls(OC_JUMP);
            6'h03, 6'h23:                      dec = mk_mem(OC_LOAD, SZ_BYTE, 1'b0);
            6'h07, 6'h27:                      dec = mk_mem(OC_LOAD, SZ_BYTE, 1'b1);
            6'h0B, 6'h2B:                      dec = mk_mem(OC_LOAD, SZ_HALF, 1'b0);
            6'h0F, 6'h2F:                      dec = mk_mem(OC_LOAD, SZ_HALF, 1'b1);
            6'h17, 6'h37:                      dec = mk_mem(OC_LOAD, SZ_WORD, 1'b0);
            6'h05, 6'h25:                      dec = mk_mem(OC_STORE, SZ_BYTE, 1'b0);
            6'h0D, 6'h2D:                      dec = mk_mem(OC_STORE, SZ_HALF, 1'b0);
            6'h15, 6'h35:                      dec = mk_mem(OC_STORE, SZ_WORD, 1'b0);
            6'h04, 6'h0C, 6'h14, 6'h1C,
            6'h24, 6'h2C, 6'h34, 6'h3C:        dec = mk_cls(OC_ALUI);
            6'h08, 6'h10, 6'h18, 6'h20,
            6'h28, 6'h30:                      dec = mk_cls(OC_CMP);
            6'h06, 6'h0E, 6'h16, 6'h1E,
            6'h26, 6'h2E, 6'h36:               dec = mk_cls(OC_BRANCH);
            6'h13, 6'h1B, 6'h33, 6'h3B:        dec = mk_cls(OC_NOP);
            6'h32, 6'h38:                      dec = mk_bad(1'b1);
            // escape opcode: the secondary decoder supplies the result
            ESC_OPC:                           dec = '0;
            default:                           dec = mk_bad(1'b0);
        endcase
    end
endmodule

// File: rtl/ifd_ext_dec.sv
module ifd_ext_dec
    import ifd_pkg::*;
(
    input  logic [OPC_W-1:0] xop,
    output dec_t             dec
);
    always_comb begin
        case (xop)
            6'h01, 6'h05, 6'h09, 6'h0D, 6'h1D: dec = mk_cls(OC_JUMP);
            6'h08, 6'h10, 6'h18, 6'h20,
            6'h28, 6'h30:                      dec = mk_cls(OC_CMP);
            6'h26, 6'h2E:                      dec = mk_cls(OC_CTRL);
            6'h2D, 6'h34:                      dec = mk_cls(OC_TRAP);
            6'h04, 6'h0C, 6'h29, 6'h36:        dec = mk_cls(OC_NOP);
            6'h02, 6'h03, 6'h06, 6'h07,
            6'h0B, 6'h0E, 6'h12, 6'h13,
            6'h16, 6'h17, 6'h1A, 6'h1B,
            6'h1C, 6'h1E, 6'h1F, 6'h24,
            6'h25, 6'h27, 6'h31, 6'h39,
            6'h3A, 6'h3B:                      dec = mk_cls(OC_ALUR);
            6'h14:                             dec = mk_bad(1'b1);
            default:                           dec = mk_bad(1'b0);
        endcase
    end
endmodule

// File: rtl/ifd_out_stage.sv
module ifd_out_stage #(
    parameter int W      = 8,
    parameter bit ENABLE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (ENABLE) begin : g_reg
            logic [W-1:0] q_r;
            always_ff @(posedge clk) begin
                if (rst) q_r <= '0;
                else     q_r <= d;
            end
            assign q = q_r;
        end else begin : g_thru
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/insn_fmt_decoder.sv
module insn_fmt_decoder
    import ifd_pkg::*;
#(
    parameter bit OUT_STAGE = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSN_W-1:0]  insn_i,
    output logic [1:0]         fmt_o,
    output logic [REG_W-1:0]   reg_a_o,
    output logic [REG_W-1:0]   reg_b_o,
    output logic [REG_W-1:0]   reg_c_o,
    output logic [IMM5_W-1:0]  imm5_o,
    output logic [IMM16_W-1:0] imm16_o,
    output logic [IMM26_W-1:0] imm26_o,
    output logic [NUM_CLS-1:0] op_class_o,
    output logic [1:0]         mem_size_o,
    output logic               mem_signed_o,
    output logic               illegal_o,
    output logic               unimpl_o
);
    localparam int DOUT_W = $bits(dout_t);

    fields_t flds;
    dec_t    pdec, xdec, sel;
    logic    is_esc;
    dout_t   comb_out, reg_out;
    logic [DOUT_W-1:0] stage_q;

    ifd_field_split u_split (.insn(insn_i), .flds(flds));
    ifd_primary_dec u_pdec  (.opc(flds.opc), .dec(pdec));
    ifd_ext_dec     u_xdec  (.xop(flds.xop), .dec(xdec));

    assign is_esc = (flds.opc == ESC_OPC);
    assign sel    = is_esc ? xdec : pdec;

    generate
        for (genvar i = 0; i < NUM_CLS; i++) begin : g_oh
            assign comb_out.cls_oh[i] = sel.cls_vld && (sel.cls == op_cls_e'(i));
        end
    endgenerate

    always_comb begin
        comb_out.ra      = flds.ra;
        comb_out.rb      = flds.rb;
        comb_out.rc      = flds.rc;
        comb_out.imm5    = flds.imm5;
        comb_out.imm16   = flds.imm16;
        comb_out.imm26   = flds.imm26;
        if (is_esc)                     comb_out.fmt = FMT_R;
        else if (flds.opc[OPC_W-1:1] == '0) comb_out.fmt = FMT_J;
        else                            comb_out.fmt = FMT_I;
        comb_out.illegal = sel.illegal;
        comb_out.unimpl  = sel.unimpl;
        comb_out.msize   = sel.msize;
        comb_out.msigned = sel.msigned;
    end

    ifd_out_stage #(.W(DOUT_W), .ENABLE(OUT_STAGE)) u_stage (
        .clk (clk),
        .rst (rst),
        .d   (comb_out),
        .q   (stage_q)
    );

    assign reg_out      = dout_t'(stage_q);
    assign fmt_o        = reg_out.fmt;
    assign reg_a_o      = reg_out.ra;
    assign reg_b_o      = reg_out.rb;
    assign reg_c_o      = reg_out.rc;
    assign imm5_o       = reg_out.imm5;
    assign imm16_o      = reg_out.imm16;
    assign imm26_o      = reg_out.imm26;
    assign op_class_o   = reg_out.cls_oh;
    assign mem_size_o   = reg_out.msize;
    assign mem_signed_o = reg_out.msigned;
    assign illegal_o    = reg_out.illegal;
    assign unimpl_o     = reg_out.unimpl;
endmodule

// File: rtl/insn_fmt_decoder_chk.sv
module insn_fmt_decoder_chk
    import ifd_pkg::*;
#(
    parameter bit OUT_STAGE = 1'b1
) (
    input logic               clk,
    input logic               rst,
    input logic [INSN_W-1:0]  insn_i,
    input logic [1:0]         fmt_o,
    input logic [REG_W-1:0]   reg_a_o,
    input logic [REG_W-1:0]   reg_b_o,
    input logic [REG_W-1:0]   reg_c_o,
    input logic [IMM5_W-1:0]  imm5_o,
    input logic [IMM16_W-1:0] imm16_o,
    input logic [IMM26_W-1:0] imm26_o,
    input logic [NUM_CLS-1:0] op_class_o,
    input logic [1:0]         mem_size_o,
    input logic               mem_signed_o,
    input logic               illegal_o,
    input logic               unimpl_o
);
    a_r13_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(illegal_o && unimpl_o));

    a_r13_class_onehot0: assert property (@(posedge clk) disable iff (rst)
        $onehot0(op_class_o));

    a_r13_class_iff_legal: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((illegal_o || unimpl_o) == (op_class_o == '0)));

    a_r12_size_idle: assert property (@(posedge clk) disable iff (rst)
        !(op_class_o[OC_LOAD] || op_class_o[OC_STORE]) |-> (mem_size_o == 2'd0 && !mem_signed_o));

    a_r5_jfmt_is_jump: assert property (@(posedge clk) disable iff (rst)
        (fmt_o == FMT_J) |-> op_class_o[OC_JUMP]);

    generate
        if (OUT_STAGE) begin : g_lat
            a_r1_fields_follow: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (reg_a_o == $past(insn_i[RA_LSB +: REG_W])
                              && reg_b_o == $past(insn_i[RB_LSB +: REG_W])
                              && reg_c_o == $past(insn_i[RC_LSB +: REG_W])
                              && imm5_o  == $past(insn_i[IMM_LSB +: IMM5_W])
                              && imm16_o == $past(insn_i[IMM_LSB +: IMM16_W])
                              && imm26_o == $past(insn_i[IMM_LSB +: IMM26_W])));

            a_r2_rfmt_on_escape: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> ((fmt_o == FMT_R) == ($past(insn_i[OPC_LSB +: OPC_W]) == ESC_OPC)));

            a_r14_reset_clears: assert property (@(posedge clk)
                $past(rst) |-> (op_class_o == '0 && fmt_o == 2'd0 && !illegal_o && !unimpl_o));
        end else begin : g_comb
            a_r1_fields_follow: assert property (@(posedge clk) disable iff (rst)
                reg_a_o == insn_i[RA_LSB +: REG_W] && imm26_o == insn_i[IMM_LSB +: IMM26_W]
                && reg_b_o == insn_i[RB_LSB +: REG_W] && reg_c_o == insn_i[RC_LSB +: REG_W]
                && imm5_o == insn_i[IMM_LSB +: IMM5_W] && imm16_o == insn_i[IMM_LSB +: IMM16_W]);
        end
    endgenerate
endmodule

bind insn_fmt_decoder insn_fmt_decoder_chk #(.OUT_STAGE(OUT_STAGE)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .insn_i       (insn_i),
    .fmt_o        (fmt_o),
    .reg_a_o      (reg_a_o),
    .reg_b_o      (reg_b_o),
    .reg_c_o      (reg_c_o),
    .imm5_o       (imm5_o),
    .imm16_o      (imm16_o),
    .imm26_o      (imm26_o),
    .op_class_o   (op_class_o),
    .mem_size_o   (mem_size_o),
    .mem_signed_o (mem_signed_o),
    .illegal_o    (illegal_o),
    .unimpl_o     (unimpl_o)
);

// File: tb/insn_fmt_decoder_tb.sv
module insn_fmt_decoder_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] insn_i = '0;
    logic [1:0]  fmt_o;
    logic [4:0]  reg_a_o, reg_b_o, reg_c_o, imm5_o;
    logic [15:0] imm16_o;
    logic [25:0] imm26_o;
    logic [9:0]  op_class_o;
    logic [1:0]  mem_size_o;
    logic        mem_signed_o, illegal_o, unimpl_o;

    int n_chk  = 0;
    int n_fail = 0;

    // expected values
    logic [9:0] e_cls;
    logic       e_ill, e_un, e_sg;
    logic [1:0] e_fmt, e_sz;
    string      e_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    insn_fmt_decoder u_dut (
        .clk(clk), .rst(rst), .insn_i(insn_i), .fmt_o(fmt_o),
        .reg_a_o(reg_a_o), .reg_b_o(reg_b_o), .reg_c_o(reg_c_o),
        .imm5_o(imm5_o), .imm16_o(imm16_o), .imm26_o(imm26_o),
        .op_class_o(op_class_o), .mem_size_o(mem_size_o),
        .mem_signed_o(mem_signed_o), .illegal_o(illegal_o), .unimpl_o(unimpl_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input logic [31:0] w);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s word=%08h actual=%0h expected=%0h", tag, w, act, exp);
        end
    endtask

    task automatic predict(input logic [31:0] w);
        logic [5:0] op, x;
        op = w[5:0];
        x  = w[16:11];
        e_cls = '0; e_ill = 0; e_un = 0; e_sz = 0; e_sg = 0;
        e_fmt = (op <= 6'd1) ? 2'd2 : (op == 6'h3A) ? 2'd1 : 2'd0;
        e_tag = "R7";
        if (op == 6'h3A) begin
            e_tag = "R11";
            if (x inside {1, 5, 9, 13, 29})                   begin e_cls = 10'd1 << 6; e_tag = "R9"; end
            else if (x inside {8, 16, 24, 32, 40, 48})        begin e_cls = 10'd1 << 4; e_tag = "R9"; end
            else if (x inside {38, 46})                       begin e_cls = 10'd1 << 7; e_tag = "R9"; end
            else if (x inside {45, 52})                       begin e_cls = 10'd1 << 8; e_tag = "R9"; end
            else if (x inside {4, 12, 41, 54})                begin e_cls = 10'd1 << 9; e_tag = "R8"; end
            else if (x inside {2, 3, 6, 7, 11, 14, 18, 19, 22, 23, 26, 27,
                               28, 30, 31, 36, 37, 39, 49, 57, 58, 59}) begin e_cls = 10'd1 << 3; e_tag = "R10"; end
            else if (x == 6'd20) e_un = 1;
            else e_ill = 1;
        end else begin
            case (op[1:0])
                2'd3: begin
                    if (op[4:2] inside {0, 1, 2, 3, 5}) begin
                        e_cls = 10'd1 << 0; e_tag = "R3";
                        e_sz  = (op[4:2] == 3'd5) ? 2'd2 : {1'b0, op[3]};
                        e_sg  = (op[4:2] != 3'd5) && op[2];
                    end else if (op[4:2] == 3'd7) e_ill = 1;
                    else begin e_cls = 10'd1 << 9; e_tag = "R8"; end
                end
                2'd0: begin
                    if (op[2]) begin e_cls = 10'd1 << 2; e_tag = "R6"; end
                    else if (op == 6'h00) begin e_cls = 10'd1 << 6; e_tag = "R5"; end
                    else if (op == 6'h38) e_un = 1;
                    else begin e_cls = 10'd1 << 4; e_tag = "R6"; end
                end
                2'd1: begin
                    if (op == 6'h01) begin e_cls = 10'd1 << 6; e_tag = "R5"; end
                    else if (op[2] && op[4:3] != 2'd3) begin
                        e_cls = 10'd1 << 1; e_tag = "R4"; e_sz = op[4:3];
                    end else e_ill = 1;
                end
                default: begin
                    if (op[2]) begin
                        if (op == 6'h3E) e_ill = 1;
                        else begin e_cls = 10'd1 << 5; e_tag = "R5"; end
                    end else if (op == 6'h32) e_un = 1;
                    else e_ill = 1;
                end
            endcase
        end
    endtask

    // drive at a falling edge, sample at the next falling edge (one register)
    task automatic apply(input logic [31:0] w);
        insn_i = w;
        predict(w);
        @(negedge clk);
        chk("R1", {27'd0, reg_a_o}, {27'd0, w[31:27]}, w);
        chk("R1", {27'd0, reg_b_o}, {27'd0, w[26:22]}, w);
        chk("R1", {27'd0, reg_c_o}, {27'd0, w[21:17]}, w);
        chk("R1", {27'd0, imm5_o},  {27'd0, w[10:6]},  w);
        chk("R1", {16'd0, imm16_o}, {16'd0, w[21:6]},  w);
        chk("R1", {6'd0, imm26_o},  {6'd0, w[31:6]},   w);
        chk("R2", {30'd0, fmt_o}, {30'd0, e_fmt}, w);
        chk(e_tag, {22'd0, op_class_o}, {22'd0, e_cls}, w);
        chk(e_tag, {30'd0, illegal_o, unimpl_o}, {30'd0, e_ill, e_un}, w);
        chk((e_cls[0] || e_cls[1]) ? e_tag : "R12", {29'd0, mem_size_o, mem_signed_o}, {29'd0, e_sz, e_sg}, w);
        chk("R13", {31'd0, (illegal_o && unimpl_o) || ($countones(op_class_o) > 1)}, 32'd0, w);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] bg [4];
        logic [9:0]  old_cls;
        bg[0] = 32'h0000_0000;
        bg[1] = 32'hFFFF_FFFF;
        bg[2] = 32'hA5C3_5A3C;
        bg[3] = 32'h5A3C_A5C3;

        repeat (3) @(negedge clk);
        // R14: outputs cleared while in reset
        chk("R14", {22'd0, op_class_o}, 32'd0, insn_i);
        chk("R14", {27'd0, fmt_o, illegal_o, unimpl_o, mem_signed_o}, 32'd0, insn_i);
        chk("R14", {6'd0, imm26_o}, 32'd0, insn_i);
        rst = 1'b0;

        // main opcode sweep over four backgrounds (R2..R8, R12, R13)
        for (int b = 0; b < 4; b++)
            for (int op = 0; op < 64; op++)
                apply((bg[b] & ~32'h3F) | 32'(op));

        // secondary opcode sweep under the escape (R8..R11)
        for (int b = 0; b < 3; b++)
            for (int x = 0; x < 64; x++)
                apply((bg[b] & ~32'h0001_F83F) | (32'(x) << 11) | 32'h3A);

        // walking one over every field bit (R1)
        for (int k = 6; k < 32; k++)
            apply((32'd1 << k) | 32'h04);

        // R14: output holds until the next edge, then follows
        apply(32'h0000_0003);
        old_cls = op_class_o;
        insn_i = 32'h0000_0006;
        #1;
        chk("R14", {22'd0, op_class_o}, {22'd0, old_cls}, insn_i);
        apply(32'h0000_0006);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule